// File: doc/BRIEF.md
# Branch and Quick-Form Instruction Decoder

This block turns one 16-bit opcode word, and the extension words that may follow it, into a decoded instruction record. It handles three opcode groups: relative branches (with condition), the quick arithmetic group (add/subtract with a small literal, decrement-and-branch, conditional set), and the move-quick form that loads a signed 8-bit literal into a data register.

An opcode is offered on `op_valid`/`op_word` and is taken while `op_ready` is high. When the opcode needs extension words, the block raises `ext_ready` and takes one word from `ext_word` on each cycle that `ext_valid` is high, until it has all of them. One cycle after the last word is taken, `res_valid` pulses for one cycle with the full record. That record holds the operation kind, condition, size, variant, a 32-bit immediate or displacement, a register number, the effective-address fields passed through, and the number of words used. The fetch logic adds that word count to the opcode address to get the next one. Memory destinations are not resolved: their mode and register fields are passed through.

Top module: `brq_decoder`

## Requirements
- R1: Bits 15:12 pick the group: 5 is quick arithmetic, 6 is branch, 7 is move-quick. Any other group gives kind 0 (invalid), a one-word count, a zero immediate and no extension words. Kind codes are: 0 invalid, 1 conditional branch, 2 subroutine branch, 3 move-quick, 4 quick add, 5 quick subtract, 6 decrement-and-branch, 7 conditional set.
- R2: For a branch, the condition output is bits 11:8. Condition 1 gives kind 2; every other condition gives kind 1.
- R3: When the low byte of a branch is neither 0x00 nor 0xFF, it is sign-extended from 8 bits. No extension word is read, the variant is 1 (byte), the size is 0 (byte) and the count is 1. Variant codes are: 0 none, 1 byte, 2 word, 3 long, 4 quick.
- R4: A branch low byte of 0xFF reads two extension words, high half first, and joins them into a 32-bit displacement. The variant is 3, the size is 2 (long) and the count is 3.
- R5: A branch low byte of 0x00 reads one extension word and sign-extends it from 16 bits. The variant is 2, the size is 1 (word) and the count is 2.
- R6: Move-quick sign-extends bits 7:0 to 32 bits and reports bits 11:9 as the register. The variant is 4, the size is 2 and the count is 1.
- R7: In group 5, when bits 7:6 are not 3, the operation is a quick add, or a quick subtract when bit 8 is set. The immediate is bits 11:9, with 0 meaning 8. The size is bits 7:6, the variant is 4, bits 5:3 and 2:0 come out as the effective-address mode and register, and the count is 1.
- R8: In group 5, when bits 7:6 are 3 and bits 5:3 are 1, the operation is decrement-and-branch (kind 6). The condition is bits 11:8 and the register is bits 2:0. One extension word is read and sign-extended as the displacement. The size is 1 and the count is 2.
- R9: In group 5, when bits 7:6 are 3 and bits 5:3 are not 1, the operation is conditional set (kind 7). The condition is bits 11:8, the size is 0 (byte), the effective-address fields pass through, and the count is 1.
- R10: `op_ready` is low while extension words are still owed, and an opcode offered then is ignored. `ext_ready` is low when no words are owed, and `ext_valid` is ignored then.
- R11: `res_valid` is high for exactly the one cycle that follows the taking of the last word of an instruction. For an instruction with no extension words, the last word is the opcode itself.
- R12: After reset, `res_valid` and `ext_ready` are low and `op_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode word offered |
| op_word | input | 16 | Opcode word |
| op_ready | output | 1 | Decoder can take an opcode |
| ext_valid | input | 1 | Extension word offered |
| ext_word | input | 16 | Extension word |
| ext_ready | output | 1 | Decoder is waiting for extension words |
| res_valid | output | 1 | Decoded record valid (one-cycle pulse) |
| res_kind | output | 3 | Operation kind code |
| res_cond | output | 4 | Condition field |
| res_size | output | 2 | Operand size code |
| res_variant | output | 3 | Variant code |
| res_imm | output | 32 | Immediate or displacement |
| res_dreg | output | 3 | Register number (move-quick target or loop counter) |
| res_ea_mode | output | 3 | Effective-address mode passed through |
| res_ea_reg | output | 3 | Effective-address register passed through |
| res_words | output | 2 | Words consumed, opcode included |

## Verification
Branches are tried with each of the three displacement forms: a positive and a negative short byte, the 0x00 sentinel with a negative word, and the 0xFF sentinel with two distinct halves. These cases separate the sign-extension paths from the join path and catch a swapped word order. Condition values 0, 1, 6 and 7 separate the subroutine case from ordinary branches. In the quick group, a zero literal checks the eight mapping, and opcodes that differ only in bits 7:6, 5:3 and 8 separate add, subtract, loop and set. Opcodes offered while busy and extension words offered while idle check that stray handshakes leave the record untouched.

// File: rtl/brq_pkg.sv
package brq_pkg;

    localparam int OP_W   = 16;
    localparam int IMM_W  = 32;
    localparam int CNT_W  = 2;

    localparam logic [3:0] GRP_QUICK  = 4'h5;
    localparam logic [3:0] GRP_BRANCH = 4'h6;
    localparam logic [3:0] GRP_MOVEQ  = 4'h7;

    localparam logic [3:0] COND_TO_SUB = 4'h1;
    localparam logic [7:0] DISP_WORD   = 8'h00;
    localparam logic [7:0] DISP_LONG   = 8'hFF;
    localparam logic [2:0] LOOP_SUB    = 3'b001;

    typedef enum logic [2:0] {
        K_INVALID = 3'd0,
        K_BCC     = 3'd1,
        K_BSR     = 3'd2,
        K_MOVEQ   = 3'd3,
        K_ADDQ    = 3'd4,
        K_SUBQ    = 3'd5,
        K_DBCC    = 3'd6,
        K_SCC     = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        V_NONE  = 3'd0,
        V_BYTE  = 3'd1,
        V_WORD  = 3'd2,
        V_LONG  = 3'd3,
        V_QUICK = 3'd4
    } variant_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } size_e;

    typedef struct packed {
        kind_e              kind;
        logic [3:0]         cond;
        size_e              size;
        variant_e           variant;
        logic [IMM_W-1:0]   imm;
        logic [2:0]         dreg;
        logic [2:0]         ea_mode;
        logic [2:0]         ea_reg;
        logic [CNT_W-1:0]   ext_need;
        logic [CNT_W-1:0]   words;
    } dec_t;

    function automatic logic [IMM_W-1:0] sext8(input logic [7:0] v);
        return {{(IMM_W-8){v[7]}}, v};
    endfunction

    function automatic logic [IMM_W-1:0] sext16(input logic [15:0] v);
        return {{(IMM_W-16){v[15]}}, v};
    endfunction

    function automatic logic [IMM_W-1:0] quick_count(input logic [2:0] f);
        return (f == 3'd0) ? IMM_W'(8) : IMM_W'(f);
    endfunction

endpackage

// File: rtl/brq_first_word.sv
module brq_first_word
    import brq_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output dec_t            dec
);
    logic [3:0] grp;
    logic [7:0] low8;

    assign grp  = op[15:12];
    assign low8 = op[7:0];

    always_comb begin
        dec          = '0;
        dec.kind     = K_INVALID;
        dec.size     = SZ_BYTE;
        dec.variant  = V_NONE;
        unique case (grp)
            GRP_BRANCH: begin
                dec.cond = op[11:8];
                dec.kind = (op[11:8] == COND_TO_SUB) ? K_BSR : K_BCC;
                if (low8 == DISP_WORD) begin
                    dec.variant  = V_WORD;
                    dec.size     = SZ_WORD;
                    dec.ext_need = 2'd1;
                end else if (low8 == DISP_LONG) begin
                    dec.variant  = V_LONG;
                    dec.size     = SZ_LONG;
                    dec.ext_need = 2'd2;
                end else begin
                    dec.variant  = V_BYTE;
                    dec.size     = SZ_BYTE;
                    dec.imm      = sext8(low8);
                end
            end
            GRP_MOVEQ: begin
                dec.kind    = K_MOVEQ;
                dec.variant = V_QUICK;
                dec.size    = SZ_LONG;
                dec.imm     = sext8(low8);
                dec.dreg    = op[11:9];
            end
            GRP_QUICK: begin
                if (op[7:6] == 2'b11) begin
                    dec.cond = op[11:8];
                    if (op[5:3] == LOOP_SUB) begin
                        dec.kind     = K_DBCC;
                        dec.size     = SZ_WORD;
                        dec.dreg     = op[2:0];
                        dec.ext_need = 2'd1;
                    end else begin
                        dec.kind    = K_SCC;
                        dec.size    = SZ_BYTE;
                        dec.ea_mode = op[5:3];
                        dec.ea_reg  = op[2:0];
                    end
                end else begin
                    dec.kind    = op[8] ? K_SUBQ : K_ADDQ;
                    dec.variant = V_QUICK;
                    dec.size    = size_e'(op[7:6]);
                    dec.imm     = quick_count(op[11:9]);
                    dec.ea_mode = op[5:3];
                    dec.ea_reg  = op[2:0];
                end
            end
            default: begin
                dec.kind = K_INVALID;
            end
        endcase
        dec.words = dec.ext_need + 2'd1;
    end

endmodule

// File: rtl/brq_ext_seq.sv
module brq_ext_seq
    import brq_pkg::*;
#(
    parameter int WORD_W = OP_W,
    parameter int NEED_W = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NEED_W-1:0] need,
    input  logic              ext_valid,
    input  logic [WORD_W-1:0] ext_word,
    output logic              ext_ready,
    output logic              done,
    output logic [WORD_W-1:0] hi_word,
    output logic [WORD_W-1:0] lo_word
);
    logic [NEED_W-1:0] remain_q;
    logic [WORD_W-1:0] hi_q;
    logic              take;

    assign ext_ready = (remain_q != '0);
    assign take      = ext_ready && ext_valid;
    assign done      = take && (remain_q == NEED_W'(1));
    assign hi_word   = hi_q;
    assign lo_word   = ext_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            hi_q     <= '0;
        end else begin
            if (take) begin
                remain_q <= remain_q - NEED_W'(1);
                hi_q     <= ext_word;
            end else if (start) begin
                remain_q <= need;
            end
        end
    end

    AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        done |=> !ext_ready); // R11

    AST_NO_START_WHILE_OWED: assert property (@(posedge clk) disable iff (rst)
        take && !done |=> ext_ready); // R10

endmodule

// File: rtl/brq_ext_merge.sv
module brq_ext_merge
    import brq_pkg::*;
(
    input  dec_t            dec_in,
    input  logic [OP_W-1:0] hi_word,
    input  logic [OP_W-1:0] lo_word,
    output dec_t            dec_out
);
    always_comb begin
        dec_out = dec_in;
        unique case (dec_in.ext_need)
            2'd1:    dec_out.imm = sext16(lo_word);
            2'd2:    dec_out.imm = {hi_word, lo_word};
            default: dec_out.imm = dec_in.imm;
        endcase
    end
endmodule

// File: rtl/brq_decoder.sv
module brq_decoder
    import brq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [15:0] op_word,
    output logic        op_ready,
    input  logic        ext_valid,
    input  logic [15:0] ext_word,
    output logic        ext_ready,
    output logic        res_valid,
    output logic [2:0]  res_kind,
    output logic [3:0]  res_cond,
    output logic [1:0]  res_size,
    output logic [2:0]  res_variant,
    output logic [31:0] res_imm,
    output logic [2:0]  res_dreg,
    output logic [2:0]  res_ea_mode,
    output logic [2:0]  res_ea_reg,
    output logic [1:0]  res_words
);
    dec_t            dec_now;
    dec_t            held_q;
    dec_t            merge_src;
    dec_t            merged;
    dec_t            res_q;
    logic            res_valid_q;
    logic            op_fire;
    logic            seq_busy;
    logic            seq_done;
    logic [OP_W-1:0] hi_word;
    logic [OP_W-1:0] lo_word;

    brq_first_word u_first (
        .op  (op_word),
        .dec (dec_now)
    );

    assign op_ready = !seq_busy;
    assign op_fire  = op_valid && op_ready;

    brq_ext_seq #(
        .WORD_W (OP_W),
        .NEED_W (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (op_fire),
        .need      (dec_now.ext_need),
        .ext_valid (ext_valid),
        .ext_word  (ext_word),
        .ext_ready (seq_busy),
        .done      (seq_done),
        .hi_word   (hi_word),
        .lo_word   (lo_word)
    );

    assign merge_src = seq_busy ? held_q : dec_now;

    brq_ext_merge u_merge (
        .dec_in  (merge_src),
        .hi_word (hi_word),
        .lo_word (lo_word),
        .dec_out (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q      <= '0;
            res_q       <= '0;
            res_valid_q <= 1'b0;
        end else begin
            if (op_fire) begin
                held_q <= dec_now;
            end
            res_valid_q <= seq_done || (op_fire && dec_now.ext_need == '0);
            if (seq_done || op_fire) begin
                res_q <= merged;
            end
        end
    end

    assign ext_ready   = seq_busy;
    assign res_valid   = res_valid_q;
    assign res_kind    = res_q.kind;
    assign res_cond    = res_q.cond;
    assign res_size    = res_q.size;
    assign res_variant = res_q.variant;
    assign res_imm     = res_q.imm;
    assign res_dreg    = res_q.dreg;
    assign res_ea_mode = res_q.ea_mode;
    assign res_ea_reg  = res_q.ea_reg;
    assign res_words   = res_q.words;

    AST_INVALID_BARE: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_kind == K_INVALID |-> res_words == 2'd1 && res_imm == '0); // R1

    AST_BYTE_ONE_WORD: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_variant == V_BYTE |-> res_words == 2'd1); // R3

    AST_LONG_THREE_WORDS: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_variant == V_LONG |-> res_words == 2'd3); // R4

    AST_QUICK_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_valid && (res_kind == K_ADDQ || res_kind == K_SUBQ)
        |-> res_imm >= 32'd1 && res_imm <= 32'd8); // R7

    AST_SET_IS_BYTE: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_kind == K_SCC |-> res_size == SZ_BYTE && res_words == 2'd1); // R9

    AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (rst)
        ext_ready |-> !op_ready); // R10

    AST_PROMPT_RESULT: assert property (@(posedge clk) disable iff (rst)
        op_fire && dec_now.ext_need == '0 |=> res_valid); // R11

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid && !op_fire && !seq_done |=> !res_valid); // R11

endmodule

// File: tb/test_brq_decoder.sv
`timescale 1ns/1ps
module test_brq_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] op_word = '0;
    logic        op_ready;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_word = '0;
    logic        ext_ready;
    logic        res_valid;
    logic [2:0]  res_kind;
    logic [3:0]  res_cond;
    logic [1:0]  res_size;
    logic [2:0]  res_variant;
    logic [31:0] res_imm;
    logic [2:0]  res_dreg;
    logic [2:0]  res_ea_mode;
    logic [2:0]  res_ea_reg;
    logic [1:0]  res_words;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    brq_decoder i_brq_decoder (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_word(op_word), .op_ready(op_ready),
        .ext_valid(ext_valid), .ext_word(ext_word), .ext_ready(ext_ready),
        .res_valid(res_valid), .res_kind(res_kind), .res_cond(res_cond),
        .res_size(res_size), .res_variant(res_variant), .res_imm(res_imm),
        .res_dreg(res_dreg), .res_ea_mode(res_ea_mode), .res_ea_reg(res_ea_reg),
        .res_words(res_words)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_res(input string tag, input int kind, input int cond, input int size,
                             input int variant, input logic [31:0] imm, input int dreg,
                             input int eam, input int ear, input int words);
        check({tag, " valid"},   32'(res_valid), 32'd1);
        check({tag, " kind"},    32'(res_kind), 32'(kind));
        check({tag, " cond"},    32'(res_cond), 32'(cond));
        check({tag, " size"},    32'(res_size), 32'(size));
        check({tag, " variant"}, 32'(res_variant), 32'(variant));
        check({tag, " imm"},     res_imm, imm);
        check({tag, " dreg"},    32'(res_dreg), 32'(dreg));
        check({tag, " ea_mode"}, 32'(res_ea_mode), 32'(eam));
        check({tag, " ea_reg"},  32'(res_ea_reg), 32'(ear));
        check({tag, " words"},   32'(res_words), 32'(words));
    endtask

    // Offers an opcode and nw extension words; returns at the negedge after the last word is taken.
    task automatic run(input logic [15:0] op, input logic [15:0] w1, input logic [15:0] w2, input int nw);
        @(negedge clk);
        op_valid = 1'b1;
        op_word  = op;
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < nw; i++) begin
            ext_valid = 1'b1;
            ext_word  = (i == 0) ? w1 : w2;
            @(negedge clk);
        end
        ext_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R12 res_valid", 32'(res_valid), 32'd0);
        check("R12 op_ready",  32'(op_ready), 32'd1);
        check("R12 ext_ready", 32'(ext_ready), 32'd0);
    endtask

    task automatic t_branch_byte;
        run(16'h6712, 16'h0, 16'h0, 0);
        check_res("R3 R2 bcc byte pos", 1, 7, 0, 1, 32'h0000_0012, 0, 0, 0, 1);
        run(16'h66FE, 16'h0, 16'h0, 0);
        check_res("R3 bcc byte neg", 1, 6, 0, 1, 32'hFFFF_FFFE, 0, 0, 0, 1);
        @(negedge clk);
        check("R11 pulse ends", 32'(res_valid), 32'd0);
    endtask

    task automatic t_branch_word;
        run(16'h6100, 16'h8000, 16'h0, 1);
        check_res("R5 R2 bsr word", 2, 1, 1, 2, 32'hFFFF_8000, 0, 0, 0, 2);
    endtask

    task automatic t_branch_long;
        run(16'h60FF, 16'h1234, 16'h5678, 2);
        check_res("R4 bra long", 1, 0, 2, 3, 32'h1234_5678, 0, 0, 0, 3);
    endtask

    task automatic t_moveq;
        run(16'h7A80, 16'h0, 16'h0, 0);
        check_res("R6 moveq", 3, 0, 2, 4, 32'hFFFF_FF80, 5, 0, 0, 1);
    endtask

    task automatic t_quick;
        run(16'h5042, 16'h0, 16'h0, 0);
        check_res("R7 addq zero is eight", 4, 0, 1, 4, 32'd8, 0, 0, 2, 1);
        run(16'h5B8B, 16'h0, 16'h0, 0);
        check_res("R7 subq", 5, 0, 2, 4, 32'd5, 0, 1, 3, 1);
    endtask

    task automatic t_loop;
        run(16'h51C9, 16'hFFFC, 16'h0, 1);
        check_res("R8 dbcc", 6, 1, 1, 0, 32'hFFFF_FFFC, 1, 0, 0, 2);
    endtask

    task automatic t_set;
        run(16'h57D0, 16'h0, 16'h0, 0);
        check_res("R9 scc", 7, 7, 0, 0, 32'd0, 0, 2, 0, 1);
        run(16'h5EF9, 16'h0, 16'h0, 0);
        check_res("R9 scc mode7", 7, 14, 0, 0, 32'd0, 0, 7, 1, 1);
    endtask

    task automatic t_invalid;
        run(16'h4E75, 16'h0, 16'h0, 0);
        check_res("R1 invalid 4", 0, 0, 0, 0, 32'd0, 0, 0, 0, 1);
        check("R1 no ext wait", 32'(ext_ready), 32'd0);
        run(16'h8000, 16'h0, 16'h0, 0);
        check_res("R1 invalid 8", 0, 0, 0, 0, 32'd0, 0, 0, 0, 1);
    endtask

    task automatic t_ext_idle;
        @(negedge clk);
        ext_valid = 1'b1;
        ext_word  = 16'h9999;
        check("R10 ext_ready idle", 32'(ext_ready), 32'd0);
        @(negedge clk);
        ext_valid = 1'b0;
        check("R10 no result from stray ext", 32'(res_valid), 32'd0);
        check("R10 still ready", 32'(op_ready), 32'd1);
        run(16'h6002, 16'h0, 16'h0, 0);
        check_res("R10 after stray ext", 1, 0, 0, 1, 32'd2, 0, 0, 0, 1);
    endtask

    task automatic t_op_busy;
        @(negedge clk);
        op_valid = 1'b1;
        op_word  = 16'h6000;
        @(negedge clk);
        op_word  = 16'h7001;
        check("R10 op_ready busy", 32'(op_ready), 32'd0);
        check("R10 ext_ready busy", 32'(ext_ready), 32'd1);
        @(negedge clk);
        op_valid  = 1'b0;
        check("R11 no early result", 32'(res_valid), 32'd0);
        ext_valid = 1'b1;
        ext_word  = 16'h0010;
        @(negedge clk);
        ext_valid = 1'b0;
        check_res("R10 busy op ignored", 1, 0, 1, 2, 32'h0000_0010, 0, 0, 0, 2);
        @(negedge clk);
        check("R10 no extra result", 32'(res_valid), 32'd0);
        check("R10 ready again", 32'(op_ready), 32'd1);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_branch_byte();
        t_branch_word();
        t_branch_long();
        t_moveq();
        t_quick();
        t_loop();
        t_set();
        t_invalid();
        t_ext_idle();
        t_op_busy();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule